// File: doc/BRIEF.md
# Glitch-free system clock source switch

This block chooses which of five free-running oscillator clocks drives the system clock. The five sources are the internal fast RC, the internal slow RC, the fast crystal, the slow crystal and the PLL. Software writes a 3-bit source code into a select field. The hardware then moves the output from the old clock to the new one without producing a runt pulse. Each source has its own ready indication. A switch is started only once the chosen source reports ready. Until then the switch waits and the old clock keeps running.

The select field holds what software asked for. A separate status field shows the source that actually drives the output. The status field changes only when the handover is complete. Software that has just written the select field can poll the status field to learn when the new clock is in use. Codes outside the five defined sources are refused.

The handover proceeds in a fixed order:
1. The old clock is gated off on one of its own falling edges, after two synchronizer stages in its domain.
2. The new clock's enable passes two synchronizer stages in the new clock's domain.
3. The new clock is released on one of its own falling edges.

Top module: `sysclk_switch`

## Requirements
- R1: After a synchronous active-low reset, the select field (register bits 2:0) and the status field (bits 6:4) both read 000, and the system clock follows source 0.
- R2: A write of a code from 0 to 4 shows in the select field on the clock after the write. The codes are: 0 internal fast RC, 1 internal slow RC, 2 fast crystal, 3 slow crystal, 4 PLL.
- R3: A write of a code from 5 to 7 is ignored. The select field, the status field and the running clock all keep their previous values.
- R4: The status field uses the same code values as the select field. Register bit 3 and bits 31:7 always read 0.
- R5: In the clock after a write that starts a switch, the status field still shows the old code. It changes only once the handover has completed.
- R6: If the selected source's ready input is low, the switch is held pending. The status field and the running clock stay on the old source until that ready input goes high. The switch then completes.
- R7: Once a switch has completed, the system clock follows the source that the status field names.
- R8: The system clock never has a high or low phase shorter than the half period of the fastest source clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register interface clock |
| rst_n | input | 1 | Synchronous active-low reset, held for several cycles of the slowest source |
| src_clk | input | 5 | Source clocks; bit index equals the source code |
| src_ready | input | 5 | Per-source ready indication; bit index equals the source code |
| wr_en | input | 1 | Write strobe for the select field |
| wr_data | input | 3 | Source code to write |
| rd_data | output | 32 | Register read value: select at bits 2:0, status at bits 6:4 |
| sys_clk | output | 1 | Glitch-free system clock |

## Verification
Suppose an enable is wrong inside the per-source gates. The bench would then see a runt pulse or an overlap of two clocks on sys_clk within a few source periods. It would also see sys_clk stop following the source named by the status field. Suppose instead a select or pending register is wrong. That shows in rd_data one interface clock after the write, or as a status field that never leaves the old code during the fixed settle window after each switch. Reserved writes and a source that is not ready are observed through rd_data and through sys_clk itself.

// File: rtl/sysclk_switch_pkg.sv
// Package: shared constants and source codes for the system clock switch.
// Assumes the source code equals the bit index of the source in all vectors.
package sysclk_switch_pkg;
    localparam int N_SRC    = 5;
    localparam int SEL_W    = 3;
    localparam int REG_W    = 32;
    localparam int SEL_LSB  = 0;
    localparam int STAT_LSB = 4;

    typedef enum logic [SEL_W-1:0] {
        SRC_IRC_FAST = 3'd0,
        SRC_IRC_SLOW = 3'd1,
        SRC_XT_FAST  = 3'd2,
        SRC_XT_SLOW  = 3'd3,
        SRC_PLL      = 3'd4
    } clk_src_e;
endpackage

// File: rtl/clksw_sync.sv
// Module: multi-stage flop synchronizer with a parameterized reset value.
// Assumes d may change at any time with respect to clk; each bit is
// synchronized on its own (bits are not coherent as a word).
module clksw_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the asynchronous input through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/clksw_branch.sv
// Module: one source's gate in the glitch-free clock switch.
// The request is synchronized on the source's rising edges. The enable is
// then updated on the source's falling edge, so it only changes while the
// source is low. Assumes rst_n is held for several periods of this source.
module clksw_branch #(
    parameter int   STAGES = 2,
    parameter logic RST_ON = 1'b0
) (
    input  logic src_clk,
    input  logic rst_n,
    input  logic req,
    output logic en_o,
    output logic gclk_o
);
    logic req_s;

    clksw_sync #(.W(1), .STAGES(STAGES), .RST_VAL(RST_ON)) u_req_sync (
        .clk   (src_clk),
        .rst_n (rst_n),
        .d     (req),
        .q     (req_s)
    );

    // Update the enable while the source clock is low.
    always_ff @(negedge src_clk) begin
        if (!rst_n) en_o <= RST_ON;
        else        en_o <= req_s;
    end

    assign gclk_o = src_clk & en_o;
endmodule

// File: rtl/clksw_regs.sv
// Module: select field, pending-source target and status field.
// The target follows the select field only while the selected source is
// ready. The status field takes the code of the single enabled source once
// exactly one enable is seen in this domain.
// Assumes src_ready and en_vec are asynchronous to clk.
module clksw_regs
    import sysclk_switch_pkg::*;
#(
    parameter int NS = N_SRC,
    parameter int SW = SEL_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_data,
    input  logic [NS-1:0] src_ready,
    input  logic [NS-1:0] en_vec,
    output logic [SW-1:0] sel_q,
    output logic [SW-1:0] tgt_q,
    output logic [SW-1:0] stat_q
);
    localparam logic [SW-1:0] MAX_CODE = SW'(NS - 1);

    logic [NS-1:0] rdy_s;
    logic [NS-1:0] en_s;
    logic [SW-1:0] enc;

    clksw_sync #(.W(NS), .STAGES(2), .RST_VAL('0)) u_rdy_sync (
        .clk (clk), .rst_n (rst_n), .d (src_ready), .q (rdy_s)
    );

    clksw_sync #(.W(NS), .STAGES(2), .RST_VAL(NS'(1))) u_en_sync (
        .clk (clk), .rst_n (rst_n), .d (en_vec), .q (en_s)
    );

    // Commanded source: accept only defined codes.
    always_ff @(posedge clk) begin
        if (!rst_n)                             sel_q <= '0;
        else if (wr_en && (wr_data <= MAX_CODE)) sel_q <= wr_data;
    end

    // Target handed to the gates: waits until the selected source is ready.
    always_ff @(posedge clk) begin
        if (!rst_n)            tgt_q <= '0;
        else if (rdy_s[sel_q]) tgt_q <= sel_q;
    end

    // Encode the enabled source into its code.
    always_comb begin
        enc = '0;
        for (int i = 0; i < NS; i++) begin
            if (en_s[i]) enc = SW'(i);
        end
    end

    // Confirmed source: updates only when exactly one gate is open.
    always_ff @(posedge clk) begin
        if (!rst_n)            stat_q <= '0;
        else if ($onehot(en_s)) stat_q <= enc;
    end
endmodule

// File: rtl/sysclk_switch.sv
// Module: top of the glitch-free system clock source switch.
// A source may ask for its gate only while every other gate is closed. This
// ordering gives break-before-make between clock domains.
// Assumes all source clocks run during reset and reset is long enough for
// the slowest one.
module sysclk_switch
    import sysclk_switch_pkg::*;
#(
    parameter int NS     = N_SRC,
    parameter int SW     = SEL_W,
    parameter int RW     = REG_W,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] src_clk,
    input  logic [NS-1:0] src_ready,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_data,
    output logic [RW-1:0] rd_data,
    output logic          sys_clk
);
    logic [SW-1:0] sel_q, tgt_q, stat_q;
    logic [NS-1:0] en, gclk, req;

    clksw_regs #(.NS(NS), .SW(SW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .src_ready (src_ready),
        .en_vec    (en),
        .sel_q     (sel_q),
        .tgt_q     (tgt_q),
        .stat_q    (stat_q)
    );

    // Request a gate only for the target and only when all others are shut.
    always_comb begin
        for (int i = 0; i < NS; i++) begin
            req[i] = (tgt_q == SW'(i)) && ((en & ~(NS'(1) << i)) == '0);
        end
    end

    for (genvar g = 0; g < NS; g++) begin : g_br
        clksw_branch #(.STAGES(STAGES), .RST_ON(1'(g == 0))) u_br (
            .src_clk (src_clk[g]),
            .rst_n   (rst_n),
            .req     (req[g]),
            .en_o    (en[g]),
            .gclk_o  (gclk[g])
        );
    end

    assign sys_clk = |gclk;

    // Register read image: select and status fields, all else zero.
    always_comb begin
        rd_data = '0;
        rd_data[SEL_LSB  +: SW] = sel_q;
        rd_data[STAT_LSB +: SW] = stat_q;
    end
endmodule

// File: rtl/clksw_checker.sv
// Module: port-level properties of the clock switch, bound to the top.
// Assumes the register field positions of the package.
module clksw_checker
    import sysclk_switch_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [SEL_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data
);
    localparam logic [SEL_W-1:0] MAXC = SEL_W'(N_SRC - 1);

    // R1: the fields come out of reset at zero.
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> rd_data[6:0] == 7'd0);

    // R2: a defined code lands in the select field one clock later.
    a_r2_valid_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data <= MAXC) |=> rd_data[SEL_LSB +: SEL_W] == $past(wr_data));

    // R3: a reserved code leaves the select field untouched.
    a_r3_reserved_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data > MAXC) |=> $stable(rd_data[SEL_LSB +: SEL_W]));

    // R4: the status field only ever holds a defined code.
    a_r4_status_defined: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[STAT_LSB +: SEL_W] <= MAXC);
endmodule

bind sysclk_switch clksw_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data)
);

// File: tb/sysclk_switch_tb_top.sv
`timescale 1ns/1ps
module sysclk_switch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        c0 = 1'b0, c1 = 1'b0, c2 = 1'b0, c3 = 1'b0, c4 = 1'b0;
    logic [4:0]  src_clk;
    logic [4:0]  src_ready = 5'b11111;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_data = 3'd0;
    logic [31:0] rd_data;
    logic        sys_clk;

    int n_chk = 0;
    int n_fail = 0;
    int glitches = 0;
    bit mon_on = 1'b0;
    realtime last_t = 0.0;

    assign src_clk = {c4, c3, c2, c1, c0};

    sysclk_switch dut_i (
        .clk (clk), .rst_n (rst_n), .src_clk (src_clk), .src_ready (src_ready),
        .wr_en (wr_en), .wr_data (wr_data), .rd_data (rd_data), .sys_clk (sys_clk)
    );

    // 200 MHz interface clock; sources offset so no edge meets a sample point.
    initial forever #2.5 clk = ~clk;
    initial begin #0.7; forever #4.0  c0 = ~c0; end
    initial begin #0.3; forever #45.0 c1 = ~c1; end
    initial begin #0.9; forever #6.0  c2 = ~c2; end
    initial begin #0.1; forever #30.0 c3 = ~c3; end
    initial begin #0.3; forever #3.0  c4 = ~c4; end

    // Runt monitor: every phase must last at least the fastest half period (3 ns).
    always @(sys_clk) begin
        if (mon_on && (($realtime - last_t) < 2.99)) glitches++;
        last_t = $realtime;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] code);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = code;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic follow(input string tag, input int k);
        int mism = 0;
        repeat (40) @(negedge clk) if (sys_clk !== src_clk[k]) mism++;
        chk(tag, mism, 0);
    endtask

    task automatic do_reset();
        mon_on = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        #1000;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 register image after reset", rd_data, 32'h0);
        #600;
        follow("R1 clock follows source 0 after reset", 0);
        last_t = $realtime;
        mon_on = 1'b1;
    endtask

    // Each vector: {written code, expected select, expected status}.
    localparam int NV = 9;
    localparam logic [8:0] VEC [NV] = '{
        {3'd2, 3'd2, 3'd2}, {3'd4, 3'd4, 3'd4}, {3'd5, 3'd4, 3'd4},
        {3'd1, 3'd1, 3'd1}, {3'd7, 3'd1, 3'd1}, {3'd3, 3'd3, 3'd3},
        {3'd0, 3'd0, 3'd0}, {3'd4, 3'd4, 3'd4}, {3'd6, 3'd4, 3'd4}
    };

    initial begin
        do_reset();
        for (int v = 0; v < NV; v++) begin
            logic [2:0] code, es, et;
            string tg;
            {code, es, et} = VEC[v];
            tg = (code > 3'd4) ? "R3" : "R2";
            wr(code);
            #3000;
            @(negedge clk);
            chk({tg, " select field"}, {29'd0, rd_data[2:0]}, {29'd0, es});
            chk({tg, " R4 status field"}, {29'd0, rd_data[6:4]}, {29'd0, et});
            chk("R4 unused bits zero", {rd_data[31:7], rd_data[3]}, 32'h0);
            follow({tg, " R7 clock follows status"}, int'(et));
        end

        // R5: status holds the old code right after the write.
        wr(3'd1);
        chk("R5 select updated", {29'd0, rd_data[2:0]}, 32'd1);
        chk("R5 status still old", {29'd0, rd_data[6:4]}, 32'd4);
        #3000;
        @(negedge clk);
        chk("R5 status after completion", {29'd0, rd_data[6:4]}, 32'd1);

        // R6: source 2 not ready, switch pending.
        src_ready[2] = 1'b0;
        #100;
        wr(3'd2);
        #3000;
        @(negedge clk);
        chk("R6 select shows request", {29'd0, rd_data[2:0]}, 32'd2);
        chk("R6 status held while pending", {29'd0, rd_data[6:4]}, 32'd1);
        follow("R6 old clock kept while pending", 1);
        src_ready[2] = 1'b1;
        #3000;
        @(negedge clk);
        chk("R6 status after ready", {29'd0, rd_data[6:4]}, 32'd2);
        follow("R6 R7 new clock after ready", 2);

        // R8: no runt phase seen across all switches.
        chk("R8 runt phases", glitches, 0);

        // R1: reset returns to source 0.
        do_reset();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule